// File: doc/BRIEF.md
# Operand Forwarding Unit for a Five-Stage Integer Pipeline

This block decides where each operand of an in-order five-stage integer pipeline comes from. It reads the instruction words held in the decode (ID), execute (EX), memory (MEM) and write-back (WB) stages. It decodes their opcodes to find out which instructions actually read registers and which actually write one. For the instruction in EX it drives the select of the operand A multiplexer and of the operand B multiplexer. Each select picks the register-file value, the result waiting in the EX/MEM register, or the result waiting in the MEM/WB register.

The register file is written only on the clock edge that ends WB. An instruction in decode that reads the same register in that cycle would therefore get the old contents. The block also drives two bypass controls at the ID/EX input, one per source, which load the MEM/WB data in place of the register-file output. The logic is purely combinational. The register file, the ALU, the multiplexers themselves and load-use stalling are outside it.

Instruction fields: opcode in bits 31-26, first source (rs1) in bits 25-21, second source (rs2) in bits 20-16, register-register destination (rd) in bits 15-11.

Top module: `fwd_unit`

## Requirements
- R1: Opcode classes: 000000 is a register-register ALU op; 001xxx is an immediate ALU op; 100xxx is a load; 101xxx is a store; 000010 is a jump; 000011 is a jump-and-link; 000100 and 000101 are branches; 010010 is a register jump; 010011 is a register jump-and-link. Every other opcode neither reads nor writes registers. With all four stages holding the all-zero word, both EX selects are 00 and both bypass controls are 0.
- R2: The EX operand A select is 01 (EX/MEM) when the MEM instruction writes a nonzero register equal to the EX rs1 field and the EX instruction uses operand A. Operand B works the same way with rs2. Operand A is used by register-register, immediate, load and store ops. Operand B is used by register-register and store ops.
- R3: A select is 10 (MEM/WB) when the WB instruction writes a nonzero register equal to that source, the operand is used, and MEM gives no match for it.
- R4: When both MEM and WB match the same used source, the select is 01.
- R5: A source field equal to register 0 never produces a nonzero select or a bypass.
- R6: When the EX instruction is a branch, jump or register jump, both EX selects are 00 whatever MEM and WB hold.
- R7: Stores, branches, jumps, register jumps and unlisted opcodes in MEM or WB are never forwarding sources.
- R8: The destination written is rd for register-register ops and the rs2 field for immediate ops and loads. Jump-and-link and register jump-and-link write register 31.
- R9: The bypass control for a decode source is 1 exactly when the decode instruction reads that source and WB writes that same nonzero register. In decode, rs1 is read by register-register, immediate, load, store, branch, register jump and register jump-and-link ops. In decode, rs2 is read by register-register and store ops.
- R10: The code 11 never appears on either EX select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_instr | input | 32 | Instruction word in the decode stage |
| ex_instr | input | 32 | Instruction word in the execute stage |
| mem_instr | input | 32 | Instruction word in the memory stage |
| wb_instr | input | 32 | Instruction word in the write-back stage |
| ex_sel_a | output | 2 | Operand A source: 00 register file, 01 EX/MEM, 10 MEM/WB |
| ex_sel_b | output | 2 | Operand B source, same encoding |
| id_byp_a | output | 1 | Load MEM/WB data for decode rs1 instead of the register file |
| id_byp_b | output | 1 | Load MEM/WB data for decode rs2 instead of the register file |

## Verification
No register lies between any input and any output, so every select and bypass is due in the same cycle as the instruction words that cause it. The bench applies a new set of four words and waits one time unit for the logic to settle. It then samples all four outputs before applying the next set, so no result can be confused with a neighbouring one. The sweep covers every pairing of nine representative opcodes across EX, MEM and WB. It combines each pairing with every placement of registers 0, 5, 9 and 31 in the source and destination fields.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int INSTR_W = 32;
    localparam int RA_W    = 5;
    localparam int OPC_W   = 6;
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RS1_LSB = OPC_LSB - RA_W;
    localparam int RS2_LSB = RS1_LSB - RA_W;
    localparam int RD_LSB  = RS2_LSB - RA_W;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_MEM = 2'b01,
        SEL_WB  = 2'b10
    } fwd_sel_e;

    typedef enum logic [3:0] {
        OC_RR,
        OC_IMM,
        OC_LOAD,
        OC_STORE,
        OC_BRANCH,
        OC_JUMP,
        OC_JLINK,
        OC_JREG,
        OC_JREGLINK,
        OC_OTHER
    } op_class_e;

    function automatic op_class_e classify(input logic [OPC_W-1:0] opc);
        op_class_e c;
        c = OC_OTHER;
        unique casez (opc)
            6'b000000: c = OC_RR;
            6'b001???: c = OC_IMM;
            6'b100???: c = OC_LOAD;
            6'b101???: c = OC_STORE;
            6'b000010: c = OC_JUMP;
            6'b000011: c = OC_JLINK;
            6'b00010?: c = OC_BRANCH;
            6'b010010: c = OC_JREG;
            6'b010011: c = OC_JREGLINK;
            default:   c = OC_OTHER;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fwd_src_decode.sv
module fwd_src_decode
    import fwd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic [RA_W-1:0]    rs1,
    output logic [RA_W-1:0]    rs2,
    output logic               ex_use_a,
    output logic               ex_use_b,
    output logic               id_use_a,
    output logic               id_use_b
);

    op_class_e cls;

    always_comb begin
        cls = classify(instr[INSTR_W-1:OPC_LSB]);
        rs1 = instr[RS1_LSB +: RA_W];
        rs2 = instr[RS2_LSB +: RA_W];
        ex_use_a = 1'b0;
        ex_use_b = 1'b0;
        id_use_a = 1'b0;
        id_use_b = 1'b0;
        unique case (cls)
            OC_RR, OC_STORE: begin
                ex_use_a = 1'b1;
                ex_use_b = 1'b1;
                id_use_a = 1'b1;
                id_use_b = 1'b1;
            end
            OC_IMM, OC_LOAD: begin
                ex_use_a = 1'b1;
                id_use_a = 1'b1;
            end
            OC_BRANCH, OC_JREG, OC_JREGLINK: begin
                id_use_a = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/fwd_dst_decode.sv
module fwd_dst_decode
    import fwd_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               wr,
    output logic [RA_W-1:0]    rd
);

    op_class_e cls;

    always_comb begin
        cls = classify(instr[INSTR_W-1:OPC_LSB]);
        wr  = 1'b0;
        rd  = '0;
        unique case (cls)
            OC_RR: begin
                wr = 1'b1;
                rd = instr[RD_LSB +: RA_W];
            end
            OC_IMM, OC_LOAD: begin
                wr = 1'b1;
                rd = instr[RS2_LSB +: RA_W];
            end
            OC_JLINK, OC_JREGLINK: begin
                wr = 1'b1;
                rd = RA_W'(LINK_REG);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
(
    input  logic [RA_W-1:0] src,
    input  logic            used,
    input  logic            mem_wr,
    input  logic [RA_W-1:0] mem_rd,
    input  logic            wb_wr,
    input  logic [RA_W-1:0] wb_rd,
    output fwd_sel_e        sel
);

    logic live;
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        live    = used && (src != '0);
        mem_hit = live && mem_wr && (mem_rd == src);
        wb_hit  = live && wb_wr && (wb_rd == src);
        if (mem_hit)
            sel = SEL_MEM;
        else if (wb_hit)
            sel = SEL_WB;
        else
            sel = SEL_RF;
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int LINK_REG = 31,
    localparam int N_OPND = 2
) (
    input  logic [INSTR_W-1:0] id_instr,
    input  logic [INSTR_W-1:0] ex_instr,
    input  logic [INSTR_W-1:0] mem_instr,
    input  logic [INSTR_W-1:0] wb_instr,
    output logic [1:0]         ex_sel_a,
    output logic [1:0]         ex_sel_b,
    output logic               id_byp_a,
    output logic               id_byp_b
);

    logic [RA_W-1:0] ex_src  [N_OPND];
    logic            ex_use  [N_OPND];
    logic [RA_W-1:0] id_src  [N_OPND];
    logic            id_use  [N_OPND];
    fwd_sel_e        ex_sel  [N_OPND];
    fwd_sel_e        id_sel  [N_OPND];
    logic            ex_idu_a, ex_idu_b;
    logic            id_exu_a, id_exu_b;
    logic            mem_wr, wb_wr;
    logic [RA_W-1:0] mem_rd, wb_rd;

    fwd_src_decode u_ex_src (
        .instr    (ex_instr),
        .rs1      (ex_src[0]),
        .rs2      (ex_src[1]),
        .ex_use_a (ex_use[0]),
        .ex_use_b (ex_use[1]),
        .id_use_a (ex_idu_a),
        .id_use_b (ex_idu_b)
    );

    fwd_src_decode u_id_src (
        .instr    (id_instr),
        .rs1      (id_src[0]),
        .rs2      (id_src[1]),
        .ex_use_a (id_exu_a),
        .ex_use_b (id_exu_b),
        .id_use_a (id_use[0]),
        .id_use_b (id_use[1])
    );

    fwd_dst_decode #(.LINK_REG(LINK_REG)) u_mem_dst (
        .instr (mem_instr),
        .wr    (mem_wr),
        .rd    (mem_rd)
    );

    fwd_dst_decode #(.LINK_REG(LINK_REG)) u_wb_dst (
        .instr (wb_instr),
        .wr    (wb_wr),
        .rd    (wb_rd)
    );

    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
        fwd_select u_ex_sel (
            .src    (ex_src[k]),
            .used   (ex_use[k]),
            .mem_wr (mem_wr),
            .mem_rd (mem_rd),
            .wb_wr  (wb_wr),
            .wb_rd  (wb_rd),
            .sel    (ex_sel[k])
        );
        // Decode-stage bypass: only the WB result can be pending a write.
        fwd_select u_id_sel (
            .src    (id_src[k]),
            .used   (id_use[k]),
            .mem_wr (1'b0),
            .mem_rd ('0),
            .wb_wr  (wb_wr),
            .wb_rd  (wb_rd),
            .sel    (id_sel[k])
        );
    end

    assign ex_sel_a = ex_sel[0];
    assign ex_sel_b = ex_sel[1];
    assign id_byp_a = (id_sel[0] == SEL_WB);
    assign id_byp_b = (id_sel[1] == SEL_WB);

    always_comb begin
        a_r10_no_code3: assert (ex_sel_a != 2'b11 && ex_sel_b != 2'b11)
            else $error("R10: reserved select code");
        a_r5_zero_src: assert ((ex_sel_a == SEL_RF || ex_src[0] != '0) &&
                               (ex_sel_b == SEL_RF || ex_src[1] != '0) &&
                               (!id_byp_a || id_src[0] != '0) &&
                               (!id_byp_b || id_src[1] != '0))
            else $error("R5: register 0 forwarded");
        a_r6_unused_opnd: assert ((ex_sel_a == SEL_RF || ex_use[0]) &&
                                  (ex_sel_b == SEL_RF || ex_use[1]))
            else $error("R6: forward to an unused operand");
        a_r9_byp_source: assert ((!id_byp_a || (wb_wr && wb_rd == id_src[0])) &&
                                 (!id_byp_b || (wb_wr && wb_rd == id_src[1])))
            else $error("R9: bypass without a WB writer");
        a_r4_mem_first: assert (ex_sel_a != SEL_WB ||
                                !(mem_wr && mem_rd == ex_src[0]))
            else $error("R4: WB chosen over a matching MEM");
    end

endmodule

// File: tb/test_fwd_unit.sv
module test_fwd_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic [31:0] id_instr, ex_instr, mem_instr, wb_instr;
    logic [1:0]  ex_sel_a, ex_sel_b;
    logic        id_byp_a, id_byp_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_unit i_fwd_unit (
        .id_instr  (id_instr),
        .ex_instr  (ex_instr),
        .mem_instr (mem_instr),
        .wb_instr  (wb_instr),
        .ex_sel_a  (ex_sel_a),
        .ex_sel_b  (ex_sel_b),
        .id_byp_a  (id_byp_a),
        .id_byp_b  (id_byp_b)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] s1,
                                       input logic [4:0] s2, input logic [4:0] d);
        return {op, s1, s2, d, 11'h000};
    endfunction

    // R1 / R8: which opcodes write and to which register
    function automatic bit writes(input logic [31:0] w);
        logic [5:0] op = w[31:26];
        return op == 6'h00 || op[5:3] == 3'b001 || op[5:3] == 3'b100 ||
               op == 6'h03 || op == 6'h13;
    endfunction

    function automatic logic [4:0] dest(input logic [31:0] w);
        logic [5:0] op = w[31:26];
        if (op == 6'h03 || op == 6'h13) return 5'd31;
        if (op == 6'h00) return w[15:11];
        return w[20:16];
    endfunction

    function automatic bit ex_uses(input logic [31:0] w, input int k);
        logic [5:0] op = w[31:26];
        if (k == 0) return op == 6'h00 || op[5:4] == 2'b00 && op[3] || op[5:4] == 2'b10;
        return op == 6'h00 || op[5:3] == 3'b101;
    endfunction

    function automatic bit id_uses(input logic [31:0] w, input int k);
        logic [5:0] op = w[31:26];
        if (k == 0) return ex_uses(w, 0) || op == 6'h04 || op == 6'h05 ||
                           op == 6'h12 || op == 6'h13;
        return ex_uses(w, 1);
    endfunction

    function automatic logic [4:0] srcf(input logic [31:0] w, input int k);
        return (k == 0) ? w[25:21] : w[20:16];
    endfunction

    function automatic logic [1:0] exp_sel(input logic [31:0] e, input logic [31:0] m,
                                           input logic [31:0] b, input int k);
        logic [4:0] s = srcf(e, k);
        bit live = ex_uses(e, k) && s != 0;
        if (live && writes(m) && dest(m) == s) return 2'b01;
        if (live && writes(b) && dest(b) == s) return 2'b10;
        return 2'b00;
    endfunction

    function automatic string tag_for(input logic [31:0] e, input logic [31:0] m,
                                      input logic [31:0] b, input int k);
        logic [4:0] s = srcf(e, k);
        bit mh = writes(m) && dest(m) == s;
        bit wh = writes(b) && dest(b) == s;
        if (!ex_uses(e, k)) return "R6";
        if (s == 0) return "R5";
        if (mh && wh) return "R4";
        if (mh) return (m[31:26] == 6'h03 || m[31:26] == 6'h13) ? "R8" : "R2";
        if (wh) return "R3";
        if (dest(m) == s || dest(b) == s) return "R7";
        return "R10";
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: ex=%h mem=%h wb=%h id=%h actual=%b expected=%b",
                     tag, ex_instr, mem_instr, wb_instr, id_instr, act, exp);
        end
    endtask

    initial begin
        logic [5:0] ops [9];
        logic [4:0] regs [4];
        ops  = '{6'h00, 6'h0a, 6'h23, 6'h2b, 6'h04, 6'h02, 6'h03, 6'h13, 6'h3f};
        regs = '{5'd0, 5'd5, 5'd9, 5'd31};

        // R1: all-zero words in every stage
        id_instr = '0; ex_instr = '0; mem_instr = '0; wb_instr = '0;
        #1;
        check("R1", ex_sel_a, 2'b00);
        check("R1", ex_sel_b, 2'b00);
        check("R1", {1'b0, id_byp_a}, 2'b00);
        check("R1", {1'b0, id_byp_b}, 2'b00);

        // R8: register jump-and-link in MEM writes 31 for an rs1 of 31
        ex_instr  = mk(6'h00, 5'd31, 5'd2, 5'd3);
        mem_instr = mk(6'h13, 5'd4, 5'd5, 5'd6);
        wb_instr  = mk(6'h3f, 5'd31, 5'd31, 5'd31);
        id_instr  = ex_instr;
        #1;
        check("R8", ex_sel_a, 2'b01);
        check("R7", ex_sel_b, 2'b00);

        for (int xo = 0; xo < 9; xo++)
        for (int mo = 0; mo < 9; mo++)
        for (int wo = 0; wo < 9; wo++)
        for (int p = 0; p < 256; p++) begin
            int a = p % 4;
            int b = (p / 4) % 4;
            int m = (p / 16) % 4;
            int w = (p / 64) % 4;
            ex_instr  = mk(ops[xo], regs[a], regs[b], regs[(a + b) % 4]);
            mem_instr = mk(ops[mo], regs[(m + 1) % 4], regs[m], regs[m]);
            wb_instr  = mk(ops[wo], regs[(w + 2) % 4], regs[w], regs[w]);
            id_instr  = ex_instr;
            #1;
            check(tag_for(ex_instr, mem_instr, wb_instr, 0), ex_sel_a,
                  exp_sel(ex_instr, mem_instr, wb_instr, 0));
            check(tag_for(ex_instr, mem_instr, wb_instr, 1), ex_sel_b,
                  exp_sel(ex_instr, mem_instr, wb_instr, 1));
            // R9: decode bypass from the WB writer only
            check("R9", {1'b0, id_byp_a},
                  {1'b0, id_uses(id_instr, 0) && srcf(id_instr, 0) != 0 &&
                         writes(wb_instr) && dest(wb_instr) == srcf(id_instr, 0)});
            check("R9", {1'b0, id_byp_b},
                  {1'b0, id_uses(id_instr, 1) && srcf(id_instr, 1) != 0 &&
                         writes(wb_instr) && dest(wb_instr) == srcf(id_instr, 1)});
            #1;
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule